// File: doc/BRIEF.md
# BCD Calculator With Cycling Display

This block is a small two-mode arithmetic unit that drives an eight-digit, active-low seven-segment bank. In the first mode it takes an 8-bit unsigned binary operand and shows its decimal value, from 0 to 255, on the three rightmost digits. In the second mode it takes two operands, each written as two BCD digits (00 to 99). It shows both operands on the left four digits and one result on the right four digits.

In the second mode, a phase counter advances on each display-rate tick. It steps from the sum to the signed difference, then to the product, and then returns to the sum. A BCD nibble above 9 is never shown as a hex glyph. Such a nibble raises an invalid flag, its own digit goes dark and the result digits go dark. All segment outputs and the flag are registered, so they follow the inputs one clock edge later.

Top module: `bcd_calc_display`

## Requirements
- R1: While `rst_n` is low at a clock edge, every segment output bit goes to 1 (all digits blank), `bad_bcd` goes to 0 and the phase returns to the sum phase.
- R2: With `op_sel` = 0, digits 2, 1 and 0 show the hundreds, tens and ones of `bin_opnd`, leading zeros included, and digits 7 to 3 are blank.
- R3: Digit k occupies `seg_out[7k+6:7k]` with bit order {g,f,e,d,c,b,a}, active low. The patterns are: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000. Blank is 1111111.
- R4: With `op_sel` = 1, digits 7 and 6 show the tens and ones nibble of `bcd_a`, and digits 5 and 4 show the tens and ones nibble of `bcd_b`.
- R5: In the sum phase (phase 0), digit 3 is blank and digits 2 to 0 show A+B in decimal, from 000 to 198.
- R6: In the difference phase (phase 1), digits 1 and 0 show |A−B| in decimal. Digit 2 shows the minus pattern 0111111 when A<B and is blank otherwise. Digit 3 is blank.
- R7: In the product phase (phase 2), digits 3 to 0 show A×B in decimal, from 0000 to 9801.
- R8: At each clock edge with `tick` high, the phase moves sum→difference→product→sum. Without `tick` the phase holds.
- R9: `bad_bcd` is high whenever any nibble of `bcd_a` or `bcd_b` exceeds 9, in either mode. In mode 1 that nibble's digit is blank, and digits 3 to 0 are all blank in every phase.
- R10: `seg_out` and `bad_bcd` reflect the inputs and phase present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 1 | 0: binary-to-decimal view, 1: BCD arithmetic view |
| bin_opnd | input | 8 | Unsigned binary operand for mode 0 |
| bcd_a | input | 8 | First BCD operand, tens in [7:4] |
| bcd_b | input | 8 | Second BCD operand, tens in [7:4] |
| tick | input | 1 | Display-rate pulse that advances the result phase |
| seg_out | output | 56 | Eight active-low segment patterns, digit 0 in [6:0] |
| bad_bcd | output | 1 | Registered flag for an illegal BCD nibble |

## Verification
A change on an operand or on `op_sel` appears on `seg_out` and `bad_bcd` at the first rising edge after it. A tick takes effect in two steps: the phase register moves at the edge that samples the tick, and the new result shows only at the following edge. The bench drives inputs one time unit after a rising edge and samples one time unit after the next edge. After each tick pulse it waits one further edge before comparing. The bench tracks the phase itself from reset and the tick count, and sweeps every binary value and every legal BCD pair through all three phases.

// File: rtl/calc_pkg.sv
// Shared types and helpers for the BCD calculator display.
// Assumes active-low segments in {g,f,e,d,c,b,a} order.
package calc_pkg;

    typedef enum logic [1:0] {
        PH_ADD = 2'd0,
        PH_SUB = 2'd1,
        PH_MUL = 2'd2
    } phase_t;

    localparam logic [6:0] SEG_BLANK = 7'b1111111;
    localparam logic [6:0] SEG_MINUS = 7'b0111111;

    // Segment pattern for one decimal digit; anything above 9 goes dark.
    function automatic logic [6:0] seg_of(input logic [3:0] d);
        case (d)
            4'd0:    seg_of = 7'b1000000;
            4'd1:    seg_of = 7'b1111001;
            4'd2:    seg_of = 7'b0100100;
            4'd3:    seg_of = 7'b0110000;
            4'd4:    seg_of = 7'b0011001;
            4'd5:    seg_of = 7'b0010010;
            4'd6:    seg_of = 7'b0000010;
            4'd7:    seg_of = 7'b1111000;
            4'd8:    seg_of = 7'b0000000;
            4'd9:    seg_of = 7'b0010000;
            default: seg_of = SEG_BLANK;
        endcase
    endfunction

    // Number of decimal digits needed to print a maximum value.
    function automatic int dec_digits(input longint unsigned maxv);
        longint unsigned v;
        int n;
        v = maxv;
        n = 1;
        while (v >= 10) begin
            v = v / 10;
            n = n + 1;
        end
        return n;
    endfunction

endpackage

// File: rtl/bcd_lane.sv
// Converts an ND-digit BCD word into its binary value and flags any
// nibble above 9. The value is meaningless when bad is high.
module bcd_lane #(
    parameter int ND = 2,
    parameter int VW = 7
) (
    input  logic [4*ND-1:0] bcd,
    output logic [VW-1:0]   value,
    output logic            bad
);
    // Horner accumulation from the most significant nibble down.
    always_comb begin
        logic [3:0] nib;
        value = '0;
        bad   = 1'b0;
        for (int i = ND - 1; i >= 0; i--) begin
            nib   = bcd[4*i +: 4];
            value = VW'(value * VW'(10)) + VW'(nib);
            bad   = bad | (nib > 4'd9);
        end
    end
endmodule

// File: rtl/dec_split.sv
// Splits a W-bit binary value into NDIG decimal digits, index 0 the ones.
// Assumes the value fits in NDIG digits; higher parts are dropped.
module dec_split #(
    parameter int W    = 8,
    parameter int NDIG = 3
) (
    input  logic [W-1:0]           bin,
    output logic [NDIG-1:0][3:0]   dig
);
    // Repeated constant divide by ten, one digit per step.
    always_comb begin
        logic [W-1:0] rem;
        rem = bin;
        for (int i = 0; i < NDIG; i++) begin
            dig[i] = 4'(rem % W'(10));
            rem    = rem / W'(10);
        end
    end
endmodule

// File: rtl/phase_seq.sv
// Result phase counter: sum, difference, product, then back to sum.
// Advances on a tick sampled at the clock edge; synchronous active-low reset.
module phase_seq
    import calc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    output phase_t phase
);
    // Step the phase on each tick, wrapping after the product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_ADD;
        end else if (tick) begin
            case (phase)
                PH_ADD:  phase <= PH_SUB;
                PH_SUB:  phase <= PH_MUL;
                default: phase <= PH_ADD;
            endcase
        end
    end

    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));

    p_wrap_after_mul_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase == PH_MUL) |=> phase == PH_ADD);

    p_never_phase3_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> phase != $past(phase));
endmodule

// File: rtl/bcd_calc_display.sv
// Two-mode calculator driving eight active-low seven-segment digits.
// Mode 0 prints an unsigned binary operand in decimal; mode 1 prints two
// BCD operands and cycles the sum, signed difference and product.
// Assumes a 2-digit BCD layout filling the 8-digit bank (default params).
module bcd_calc_display
    import calc_pkg::*;
#(
    parameter int OPW        = 8,
    parameter int BCD_DIGITS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_sel,
    input  logic [OPW-1:0]            bin_opnd,
    input  logic [4*BCD_DIGITS-1:0]   bcd_a,
    input  logic [4*BCD_DIGITS-1:0]   bcd_b,
    input  logic                      tick,
    output logic [28*BCD_DIGITS-1:0]  seg_out,
    output logic                      bad_bcd
);
    localparam int D       = BCD_DIGITS;
    localparam int VW      = $clog2(10 ** D);
    localparam int SUMW    = VW + 1;
    localparam int PRODW   = 2 * VW;
    localparam int BIN_DIG = dec_digits(longint'(2) ** OPW - 1);
    localparam int RES_DIG = 2 * D;
    localparam int NUM_DIG = 4 * D;

    logic [VW-1:0]    a_val, b_val, diff;
    logic             a_bad, b_bad, any_bad, a_less;
    logic [SUMW-1:0]  sum;
    logic [PRODW-1:0] prod;
    phase_t           phase;

    logic [BIN_DIG-1:0][3:0] bin_d;
    logic [D:0][3:0]         sum_d;
    logic [D-1:0][3:0]       diff_d;
    logic [2*D-1:0][3:0]     prod_d;
    logic [NUM_DIG-1:0][6:0] dig_n;

    bcd_lane #(.ND(D), .VW(VW)) u_lane_a (.bcd(bcd_a), .value(a_val), .bad(a_bad));
    bcd_lane #(.ND(D), .VW(VW)) u_lane_b (.bcd(bcd_b), .value(b_val), .bad(b_bad));

    // Arithmetic on the binary operand values.
    always_comb begin
        any_bad = a_bad | b_bad;
        a_less  = a_val < b_val;
        sum     = SUMW'(a_val) + SUMW'(b_val);
        diff    = a_less ? (b_val - a_val) : (a_val - b_val);
        prod    = PRODW'(a_val) * PRODW'(b_val);
    end

    dec_split #(.W(OPW),   .NDIG(BIN_DIG)) u_split_bin  (.bin(bin_opnd), .dig(bin_d));
    dec_split #(.W(SUMW),  .NDIG(D + 1))   u_split_sum  (.bin(sum),      .dig(sum_d));
    dec_split #(.W(VW),    .NDIG(D))       u_split_diff (.bin(diff),     .dig(diff_d));
    dec_split #(.W(PRODW), .NDIG(2 * D))   u_split_prod (.bin(prod),     .dig(prod_d));

    phase_seq u_phase (.clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase));

    // Compose the next digit patterns for the current mode and phase.
    always_comb begin
        for (int k = 0; k < NUM_DIG; k++) dig_n[k] = SEG_BLANK;
        if (!op_sel) begin
            for (int i = 0; i < BIN_DIG; i++) dig_n[i] = seg_of(bin_d[i]);
        end else begin
            for (int i = 0; i < D; i++) begin
                dig_n[RES_DIG + D + i] = seg_of(bcd_a[4*i +: 4]);
                dig_n[RES_DIG + i]     = seg_of(bcd_b[4*i +: 4]);
            end
            if (!any_bad) begin
                case (phase)
                    PH_ADD: for (int i = 0; i <= D; i++) dig_n[i] = seg_of(sum_d[i]);
                    PH_SUB: begin
                        for (int i = 0; i < D; i++) dig_n[i] = seg_of(diff_d[i]);
                        if (a_less) dig_n[D] = SEG_MINUS;
                    end
                    PH_MUL: for (int i = 0; i < 2 * D; i++) dig_n[i] = seg_of(prod_d[i]);
                    default: ;
                endcase
            end
        end
    end

    // Register the display and the invalid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_out <= '1;
            bad_bcd <= 1'b0;
        end else begin
            seg_out <= dig_n;
            bad_bcd <= any_bad;
        end
    end

    // Marks that one full cycle has passed since reset release.
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_reset_blank_r1: assert property (@(posedge clk)
        !rst_n |=> (seg_out == '1 && !bad_bcd));

    p_mode0_upper_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(op_sel)) |-> seg_out[NUM_DIG*7-1:BIN_DIG*7] == '1);

    p_bad_blanks_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_sel) && bad_bcd) |-> seg_out[RES_DIG*7-1:0] == '1);

    p_minus_only_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_sel) && seg_out[D*7 +: 7] == SEG_MINUS) |-> $past(phase) == PH_SUB);

    p_mul_no_minus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_sel) && $past(phase) == PH_MUL) |-> seg_out[D*7 +: 7] != SEG_MINUS);
endmodule

// File: tb/sim_bcd_calc_display.sv
module sim_bcd_calc_display;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_sel = 1'b0;
    logic [7:0]  bin_opnd = 8'd0;
    logic [7:0]  bcd_a = 8'hFF;
    logic [7:0]  bcd_b = 8'h00;
    logic        tick = 1'b0;
    logic [55:0] seg_out;
    logic        bad_bcd;

    int checks = 0;
    int fails  = 0;
    int ph     = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bcd_calc_display u0 (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .bin_opnd(bin_opnd),
        .bcd_a(bcd_a), .bcd_b(bcd_b), .tick(tick),
        .seg_out(seg_out), .bad_bcd(bad_bcd)
    );

    // R3 pattern table
    function automatic logic [6:0] s7(input int d);
        case (d)
            0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
            4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
            8: return 7'h00; 9: return 7'h10;
            default: return 7'h7F;
        endcase
    endfunction

    function automatic logic [55:0] expect_v(input bit op, input int bin,
                                             input logic [7:0] a, input logic [7:0] b,
                                             input int p);
        logic [55:0] v;
        int av, bv, r;
        bit bad;
        v = '1;
        if (!op) begin
            v[6:0]   = s7(bin % 10);
            v[13:7]  = s7((bin / 10) % 10);
            v[20:14] = s7(bin / 100);
        end else begin
            v[55:49] = s7(int'(a[7:4]));
            v[48:42] = s7(int'(a[3:0]));
            v[41:35] = s7(int'(b[7:4]));
            v[34:28] = s7(int'(b[3:0]));
            bad = (a[7:4] > 9) || (a[3:0] > 9) || (b[7:4] > 9) || (b[3:0] > 9);
            av = int'(a[7:4]) * 10 + int'(a[3:0]);
            bv = int'(b[7:4]) * 10 + int'(b[3:0]);
            if (!bad) begin
                if (p == 0) begin
                    r = av + bv;
                    v[6:0] = s7(r % 10); v[13:7] = s7((r / 10) % 10); v[20:14] = s7(r / 100);
                end else if (p == 1) begin
                    r = (av >= bv) ? av - bv : bv - av;
                    v[6:0] = s7(r % 10); v[13:7] = s7(r / 10);
                    if (av < bv) v[20:14] = 7'b0111111;
                end else begin
                    r = av * bv;
                    v[6:0] = s7(r % 10); v[13:7] = s7((r / 10) % 10);
                    v[20:14] = s7((r / 100) % 10); v[27:21] = s7(r / 1000);
                end
            end
        end
        return v;
    endfunction

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_seg(input string req, input logic [55:0] exp);
        checks++;
        if (seg_out !== exp) begin
            fails++;
            $display("FAIL %s seg_out actual=%h expected=%h", req, seg_out, exp);
        end
    endtask

    task automatic chk_bad(input string req, input bit exp);
        checks++;
        if (bad_bcd !== exp) begin
            fails++;
            $display("FAIL %s bad_bcd actual=%b expected=%b", req, bad_bcd, exp);
        end
    endtask

    function automatic bit is_bad(input logic [7:0] a, input logic [7:0] b);
        return (a[7:4] > 9) || (a[3:0] > 9) || (b[7:4] > 9) || (b[3:0] > 9);
    endfunction

    function automatic string ph_req(input int p);
        if (p == 0) return "R5 R4 R10";
        if (p == 1) return "R6 R4 R10";
        return "R7 R4 R10";
    endfunction

    // Apply an operand pair and check all three phases in turn (R8 sequencing).
    task automatic run_pair(input logic [7:0] a, input logic [7:0] b);
        bcd_a = a; bcd_b = b;
        settle();
        chk_seg(is_bad(a, b) ? "R9" : ph_req(ph), expect_v(1'b1, 0, a, b, ph));
        for (int t = 0; t < 3; t++) begin
            tick = 1'b1;
            settle();
            tick = 1'b0;
            ph = (ph + 1) % 3;
            settle();
            chk_seg(is_bad(a, b) ? "R9" : {ph_req(ph), " R8"}, expect_v(1'b1, 0, a, b, ph));
        end
        chk_bad("R9", is_bad(a, b));
    endtask

    initial begin
        // Reset with an illegal nibble present: flag must stay low.
        repeat (3) settle();
        chk_seg("R1", '1);
        chk_bad("R1", 1'b0);
        rst_n = 1'b1;
        ph = 0;

        // Mode 0 sweep over every binary value, with a legal BCD pair present.
        bcd_a = 8'h12; bcd_b = 8'h34;
        op_sel = 1'b0;
        for (int v = 0; v < 256; v++) begin
            bin_opnd = 8'(v);
            settle();
            chk_seg("R2 R3 R10", expect_v(1'b0, v, 8'h0, 8'h0, ph));
        end
        chk_bad("R9", 1'b0);

        // Mode 0 with an illegal BCD nibble: display unaffected, flag high.
        bcd_a = 8'hA5; bin_opnd = 8'd207;
        settle();
        chk_seg("R2", expect_v(1'b0, 207, 8'h0, 8'h0, ph));
        chk_bad("R9", 1'b1);

        // Mode 1 exhaustive sweep of legal pairs.
        op_sel = 1'b1;
        for (int i = 0; i < 100; i++) begin
            for (int j = 0; j < 100; j++) begin
                run_pair(8'(((i / 10) << 4) | (i % 10)), 8'(((j / 10) << 4) | (j % 10)));
            end
        end

        // Illegal nibble in each position, every illegal code.
        for (int pos = 0; pos < 4; pos++) begin
            for (int n = 10; n < 16; n++) begin
                logic [15:0] w;
                w = 16'h3737;
                w[4*pos +: 4] = 4'(n);
                run_pair(w[15:8], w[7:0]);
            end
        end

        // Phase holds without a tick.
        bcd_a = 8'h25; bcd_b = 8'h71;
        settle();
        chk_seg(ph_req(ph), expect_v(1'b1, 0, 8'h25, 8'h71, ph));
        repeat (6) settle();
        chk_seg("R8", expect_v(1'b1, 0, 8'h25, 8'h71, ph));

        // Reset mid-cycle returns to sum phase and blank display.
        tick = 1'b1; settle(); tick = 1'b0; ph = (ph + 1) % 3;
        rst_n = 1'b0;
        settle();
        chk_seg("R1", '1);
        chk_bad("R1", 1'b0);
        rst_n = 1'b1; ph = 0;
        settle();
        chk_seg("R1 R5", expect_v(1'b1, 0, 8'h25, 8'h71, 0));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule